// File: doc/BRIEF.md
# PLL Output Clock Divider and Reference Status Controller

This block runs on the VCO clock. From that clock it produces two clock-enable strobes: one for the PLL output clock and one for the bus clock. The PLL output rate is the VCO rate divided by a programmable post-divider value plus one. The bus rate is half of that. For example, a 64 MHz VCO with a post-divider of 3 yields a 16 MHz PLL strobe rate and an 8 MHz bus strobe rate.

While the lock input is low, the divider ignores the programmed value and divides by four. The programmed ratio returns once lock returns. The oscillator-qualified status is valid only while the PLL is locked, because the filter that qualifies the oscillator runs from the VCO.

The block comes out of reset using the internal reference. Software moves it to the external-oscillator reference in this order:
1. Program the post-divider.
2. Enable the oscillator.
3. Wait for lock and for the oscillator to be qualified.
4. Clear the change flags.
5. Optionally enable the status interrupts.

If the external reference is selected while the oscillator is not qualified, the block falls back to the internal reference and reports this on a status pin. All pins are plain control and status signals: there is no data stream and no handshake.

Top module: `pllc_top`

## Requirements
- R1: After reset, `lock_o`, `osc_ok_o`, `flags_o`, `irq_o`, `ext_active_o` and `fallback_o` are all 0. The post-divider resets to 3.
- R2: While lock is held high, `pll_ce_o` pulses once every (post-divider + 1) VCO cycles. The post-divider is written at address 0, bits [PDIV_W-1:0]. A value of 0 gives a pulse every cycle.
- R3: `bus_ce_o` pulses on every second `pll_ce_o` pulse, in the same cycle as that pulse, and never in two consecutive cycles.
- R4: While lock is low, `pll_ce_o` pulses once every 4 cycles, whatever the post-divider holds.
- R5: A write to the post-divider takes effect only at the next counter wrap. The period already in progress, and a wrap in the same cycle as the write, still use the old ratio.
- R6: `osc_ok_o` is the AND of `lock_i`, `osc_qual_i` and the oscillator-enable bit, registered once. The oscillator-enable bit is address 1, bit 0. Driving `lock_i` low therefore forces `osc_ok_o` to 0 on the next cycle.
- R7: `flags_o[0]` sets on any edge of `lock_o`, and `flags_o[1]` sets on any edge of `osc_ok_o`. Each flag is set two cycles after its input changes. Writing a 1 to the matching bit of address 2 clears the flag. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq_o` is the OR over both flags of the flag ANDed with its enable bit. The enables are address 3: bit 0 for lock, bit 1 for oscillator.
- R9: `ext_active_o` is high when the external-select bit (address 1, bit 1) is set and `osc_ok_o` is high. `fallback_o` is high when that select bit is set and `osc_ok_o` is low. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | PLL lock indication |
| osc_qual_i | input | 1 | Oscillator qualified by the spike filter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 post-divider, 1 control, 2 flag clear, 3 interrupt enables |
| wr_data | input | DW | Register write data |
| pll_ce_o | output | 1 | PLL output clock enable strobe |
| bus_ce_o | output | 1 | Bus clock enable strobe |
| lock_o | output | 1 | Registered lock status |
| osc_ok_o | output | 1 | Oscillator-qualified status |
| flags_o | output | 2 | Change flags: bit 0 lock, bit 1 oscillator |
| irq_o | output | 1 | Interrupt request |
| ext_active_o | output | 1 | External reference in use |
| fallback_o | output | 1 | External selected but internal reference used |

## Verification
The bench builds the block with its defaults: `PDIV_W` = 5 and `DW` = 8.

With these values, every post-divider from 0 to 31 can be reached. That covers the divide-by-one case, where the counter wraps every cycle, and the longest period of 32 cycles. Random post-divider values and random flag-clear and enable writes are mixed with directed checks of four things: the unlocked divide-by-four, the ratio change at a wrap, the lock-loss clearing of oscillator status, and the fallback indication.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int ADDR_W = 2;
  localparam int NFLAG = 2;
  localparam int FLAG_LOCK = 0;
  localparam int FLAG_OSC = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_PDIV = 2'd0,
    REG_CTRL = 2'd1,
    REG_FLAG = 2'd2,
    REG_IEN  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pllc_regs.sv
module pllc_regs
  import pllc_pkg::*;
#(
  parameter int PDIV_W = 5,
  parameter int DW = 8,
  parameter int PDIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [PDIV_W-1:0] pdiv_q,
  output logic              osc_en_q,
  output logic              ext_sel_q,
  output logic [NFLAG-1:0]  ien_q,
  output logic [NFLAG-1:0]  clr
);
  reg_addr_e addr;
  logic      unused_hi;

  assign addr = reg_addr_e'(wr_addr);
  assign unused_hi = ^wr_data[DW-1:PDIV_W];
  assign clr = (wr_en && addr == REG_FLAG) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_q    <= PDIV_W'(PDIV_RST);
      osc_en_q  <= 1'b0;
      ext_sel_q <= 1'b0;
      ien_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_PDIV: pdiv_q <= wr_data[PDIV_W-1:0];
        REG_CTRL: begin
          osc_en_q  <= wr_data[0];
          ext_sel_q <= wr_data[1];
        end
        REG_IEN:  ien_q <= wr_data[NFLAG-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pllc_div.sv
module pllc_div #(
  parameter int PDIV_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic [PDIV_W-1:0] pdiv,
  output logic              pll_ce,
  output logic              bus_ce
);
  localparam logic [PDIV_W-1:0] UNLOCK_LIM = PDIV_W'(3);

  logic [PDIV_W-1:0] cnt;
  logic [PDIV_W-1:0] lim_q;
  logic              phase;
  logic              wrap;

  assign wrap   = (cnt == lim_q);
  assign pll_ce = wrap;
  assign bus_ce = wrap & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lim_q <= UNLOCK_LIM;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      lim_q <= locked ? pdiv : UNLOCK_LIM;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_UNLOCK_DIV4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !locked) |=> (lim_q == UNLOCK_LIM)); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= lim_q)); // R2
  AST_BUS_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce |=> !bus_ce); // R3
endmodule

// File: rtl/pllc_status.sv
module pllc_status
  import pllc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             osc_qual_i,
  input  logic             osc_en,
  input  logic             ext_sel,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] ien,
  output logic             lock_q,
  output logic             osc_ok,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             ext_active,
  output logic             fallback
);
  logic             lock_d;
  logic             osc_d;
  logic [NFLAG-1:0] edge_det;

  assign edge_det[FLAG_LOCK] = lock_q ^ lock_d;
  assign edge_det[FLAG_OSC]  = osc_ok ^ osc_d;
  assign irq        = |(flags & ien);
  assign ext_active = ext_sel & osc_ok;
  assign fallback   = ext_sel & ~osc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      osc_ok <= 1'b0;
      lock_d <= 1'b0;
      osc_d  <= 1'b0;
      flags  <= '0;
    end else begin
      lock_q <= lock_i;
      osc_ok <= lock_i & osc_qual_i & osc_en;
      lock_d <= lock_q;
      osc_d  <= osc_ok;
      flags  <= (flags & ~clr) | edge_det;
    end
  end

  AST_OSC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> !osc_ok); // R6
  AST_FLAG_SETS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != lock_d) |=> flags[FLAG_LOCK]); // R7
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[FLAG_OSC] && (osc_ok == osc_d)) |=> !flags[FLAG_OSC]); // R7
  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_active, fallback})); // R9
endmodule

// File: rtl/pllc_top.sv
module pllc_top
  import pllc_pkg::*;
#(
  parameter int PDIV_W = 5,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              osc_qual_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              pll_ce_o,
  output logic              bus_ce_o,
  output logic              lock_o,
  output logic              osc_ok_o,
  output logic [1:0]        flags_o,
  output logic              irq_o,
  output logic              ext_active_o,
  output logic              fallback_o
);
  logic [PDIV_W-1:0] pdiv_q;
  logic              osc_en_q;
  logic              ext_sel_q;
  logic [NFLAG-1:0]  ien_q;
  logic [NFLAG-1:0]  clr;

  pllc_regs #(.PDIV_W(PDIV_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pdiv_q(pdiv_q), .osc_en_q(osc_en_q),
    .ext_sel_q(ext_sel_q), .ien_q(ien_q), .clr(clr)
  );

  pllc_status u_status (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .osc_qual_i(osc_qual_i),
    .osc_en(osc_en_q), .ext_sel(ext_sel_q), .clr(clr), .ien(ien_q),
    .lock_q(lock_o), .osc_ok(osc_ok_o), .flags(flags_o), .irq(irq_o),
    .ext_active(ext_active_o), .fallback(fallback_o)
  );

  pllc_div #(.PDIV_W(PDIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .locked(lock_o), .pdiv(pdiv_q),
    .pll_ce(pll_ce_o), .bus_ce(bus_ce_o)
  );
endmodule

// File: tb/tb_pllc_top.sv
module tb_pllc_top;
  localparam int PDIV_W = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_i = 1'b0, osc_qual_i = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic pll_ce_o, bus_ce_o, lock_o, osc_ok_o, irq_o, ext_active_o, fallback_o;
  logic [1:0] flags_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [1:0] ien_m = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pllc_top #(.PDIV_W(PDIV_W), .DW(DW)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input bit locked, input int pd);
    return locked ? pd + 1 : 4;
  endfunction

  function automatic bit exp_irq(input logic [1:0] fl, input logic [1:0] en);
    return |(fl & en);
  endfunction

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ce(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pll_ce_o);
  endtask

  task automatic check_period(input int exp, input string req);
    int n, nbus;
    wait_ce(n);
    wait_ce(n);
    wait_ce(n);
    nbus = 0;
    for (int k = 0; k < 4; k++) begin
      wait_ce(n);
      if (bus_ce_o) nbus++;
      check(n == exp, req, n, exp);
    end
    check(nbus == 2, "R3", nbus, 2);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({lock_o, osc_ok_o, flags_o, irq_o, ext_active_o, fallback_o} == 7'd0,
          "R1", {lock_o, osc_ok_o, flags_o, irq_o, ext_active_o, fallback_o}, 0);
    // R1 / R4: default divide by four while unlocked
    check_period(4, "R1");
    wr(2'd0, 9);
    check_period(exp_period(0, 9), "R4");
    // R2: lock gives programmed ratio
    lock_i = 1'b1;
    check_period(exp_period(1, 9), "R2");
    check(flags_o[0] == 1'b1, "R7", flags_o[0], 1);
    check(irq_o == exp_irq(flags_o, ien_m), "R8", irq_o, 0);
    wr(2'd3, 1); ien_m = 2'b01;
    check(irq_o == 1'b1, "R8", irq_o, 1);
    wr(2'd2, 1);
    check(flags_o[0] == 1'b0, "R7", flags_o[0], 0);
    check(irq_o == 1'b0, "R8", irq_o, 0);
    // R2 corner: divide by one
    wr(2'd0, 0);
    check_period(1, "R2");
    // R5: write at the wrap cycle, old ratio holds for one period
    wr(2'd0, 7);
    check_period(8, "R2");
    wait_ce(n);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = DW'(2);
    @(negedge clk); wr_en = 1'b0;
    n = 1;
    while (!pll_ce_o) begin @(negedge clk); n++; end
    check(n == 8, "R5", n, 8);
    wait_ce(n);
    check(n == 3, "R5", n, 3);
    // R6 / R9
    osc_qual_i = 1'b1;
    wr(2'd1, 2'b01);
    @(negedge clk);
    check(osc_ok_o == 1'b1, "R6", osc_ok_o, 1);
    wr(2'd1, 2'b11);
    check(ext_active_o == 1'b1 && fallback_o == 1'b0, "R9", {ext_active_o, fallback_o}, 2);
    wr(2'd2, 3);
    lock_i = 1'b0;
    @(negedge clk);
    check(osc_ok_o == 1'b0, "R6", osc_ok_o, 0);
    check(ext_active_o == 1'b0 && fallback_o == 1'b1, "R9", {ext_active_o, fallback_o}, 1);
    repeat (2) @(negedge clk);
    check(flags_o == 2'b11, "R7", flags_o, 3);
    check_period(exp_period(0, 2), "R4");
    // R7: set wins over clear in the same cycle
    wr(2'd2, 3);
    lock_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = DW'(1);
    @(negedge clk); wr_en = 1'b0;
    check(flags_o[0] == 1'b1, "R7", flags_o[0], 1);
    // Random post-divider values while locked
    for (int i = 0; i < 20; i++) begin
      int pd;
      pd = $urandom_range(0, 31);
      wr(2'd0, pd);
      check_period(exp_period(1, pd), "R2");
    end
    // Random enable and clear writes against the irq model
    for (int i = 0; i < 30; i++) begin
      int d;
      d = $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 1) begin
        wr(2'd3, d); ien_m = 2'(d);
      end else begin
        wr(2'd2, d);
      end
      lock_i = ($urandom_range(0, 3) != 0);
      repeat (3) @(negedge clk);
      check(irq_o == exp_irq(flags_o, ien_m), "R8", irq_o, exp_irq(flags_o, ien_m));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule